// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one outgoing low-speed USB packet onto the D+ and D- lines. A packet is 2 to 12 bytes long, and that count includes the sync byte. The block makes the sync byte itself and fetches the remaining bytes one at a time from an external byte buffer through a combinational read port. Each bit is NRZI-coded and occupies a fixed whole number of clock cycles. The block inserts a stuffed bit after every run of six ones. After the last bit it drives the end-of-packet sequence, then hands the lines back.

A second start mode sends a two-byte handshake reply, sync followed by an ACK or NAK PID, without touching the buffer. A pending device address is copied to the active address register when a data packet ends, but not when a handshake ends. A pending receive-edge flag is cleared when any transmission ends. A response-window monitor measures the time from the last received end-of-packet to the accepted start and flags a start that comes too late.

The controller has five states, which follow each other in a fixed order:

- IDLE: the lines are released. An accepted start moves the block to PREP.
- PREP: the block presents J on the lines for one cycle while the drivers are still off, then moves to DATA.
- DATA: the block sends bit slots. At the end of each slot it either starts the next slot or, when no bits remain, moves to SE0.
- SE0: the block holds both lines low for two bit times, then moves to EOPJ.
- EOPJ: the block drives J for one cycle, then returns to IDLE.

Top module: `usb_ls_tx`

## Requirements
- R1: A start in IDLE is accepted when `hs_mode`=1, or when `byte_cnt` is 2..12. A start with any other count, or a start while `busy`, is ignored: the block stays idle or its packet timing is unchanged.
- R2: The cycle after the edge that samples an accepted start is PREP: `busy`=1, `drive_en`=0, `dp_out`=0, `dm_out`=1. The next cycle has `drive_en`=1.
- R3: Bit slot k lasts exactly CYC_PER_BIT cycles and starts 2+k*CYC_PER_BIT cycles after the start edge. Bytes go out LSB first: first the sync byte 0x80, then buffer entries `rd_addr`=0..byte_cnt-2.
- R4: The line level before the first slot is J (`dp_out`=0, `dm_out`=1). A 0 bit toggles between J and K (`dp_out`=1, `dm_out`=0), and a 1 bit holds the level. Both outputs are never high together.
- R5: After six consecutive 1 bits, counting across byte borders, a stuffed 0 slot is inserted, including after the final bit. The run count starts from zero at each packet.
- R6: After the last slot, both lines are low with `drive_en`=1 for 2*CYC_PER_BIT cycles. Then J is driven for one cycle. Then `drive_en`=0 and both lines are 0, and they stay that way while idle.
- R7: With `hs_mode`=1, the packet is sync followed by ACK 0xD2 (`hs_nak`=0) or NAK 0x5A (`hs_nak`=1), and `byte_cnt` is ignored.
- R8: `done` is high for exactly one cycle, the first IDLE cycle after EOPJ. `busy` is high from PREP through EOPJ.
- R9: `dev_addr` takes `new_addr` on the edge that ends a data packet. It is unchanged after a handshake and at all other times.
- R10: `rx_irq` is set by `rx_edge` and is cleared on the edge that ends a transmission, so it reads 0 while `done` is high.
- R11: `too_late` pulses for one cycle after an accepted start when that start was sampled more than (15*CYC_PER_BIT)/2 edges after the edge that sampled `eop_seen`. An accepted start disarms the monitor until the next `eop_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled in IDLE |
| hs_mode | input | 1 | 1 = send a handshake reply instead of buffer data |
| hs_nak | input | 1 | Handshake PID select: 0 = ACK, 1 = NAK |
| byte_cnt | input | 4 | Packet length including sync (2..12) |
| rd_addr | output | 4 | Buffer index of the next byte to fetch |
| rd_data | input | 8 | Buffer byte at `rd_addr` |
| eop_seen | input | 1 | Pulse at the end of a received packet |
| rx_edge | input | 1 | Receive-edge event |
| new_addr | input | 7 | Pending device address |
| dev_addr | output | 7 | Active device address |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle end-of-transmission pulse |
| too_late | output | 1 | Response started outside the window |
| rx_irq | output | 1 | Pending receive-edge flag |
| dp_out | output | 1 | D+ line value |
| dm_out | output | 1 | D- line value |
| drive_en | output | 1 | Line driver enable |

## Verification
Every result is due at a fixed distance from the start edge:

- PREP is visible one cycle after the start edge.
- Bit slot k begins 2+k*CYC_PER_BIT cycles after the start edge.
- SE0 begins right after the last slot, which may be a stuffed one. EOPJ follows 2*CYC_PER_BIT cycles later, and `done`, the address commit and the cleared `rx_irq` appear in the cycle after EOPJ.
- `too_late` is visible in the PREP cycle.

The bench walks these positions with a falling-edge counter. It samples each slot at its middle, and it samples SE0 at both its first and last cycle so that the length is pinned exactly. The expected line levels come from a stuffing-and-NRZI model built from the packet bytes. The sweep covers every legal length with four data patterns and both handshake PIDs.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DATA,
        ST_SE0,
        ST_EOPJ
    } tx_state_t;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;

endpackage

// File: rtl/usb_ls_tx_timer.sv
// Slot counter: counts 0..lim-1 and wraps, held at zero while cleared.
module usb_ls_tx_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = (cnt_q == lim - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/usb_ls_tx_ser.sv
// Bit source with stuffing: decides at every slot start whether the slot
// carries the next data bit or a stuffed zero.
module usb_ls_tx_ser #(
    parameter int CNT_W     = 4,
    parameter int RA_W      = 4,
    parameter int STUFF_RUN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] nbytes,
    input  logic             adv,
    input  logic [7:0]       byte_in,
    output logic [RA_W-1:0]  rd_addr,
    output logic             toggle,
    output logic             more
);
    import usb_ls_tx_pkg::*;

    localparam int ONES_W = $clog2(STUFF_RUN + 1);

    logic [7:0]       shreg_q;
    logic [2:0]       bit_q;
    logic [CNT_W-1:0] left_q;
    logic [ONES_W-1:0] ones_q;
    logic             fin_q;
    logic [RA_W-1:0]  addr_q;
    logic             stuff;

    assign stuff   = (ones_q == ONES_W'(STUFF_RUN));
    assign toggle  = stuff || !shreg_q[0];
    assign more    = !fin_q || stuff;
    assign rd_addr = addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
            left_q  <= '0;
            ones_q  <= '0;
            fin_q   <= 1'b1;
            addr_q  <= '0;
        end else if (ld) begin
            shreg_q <= SYNC_BYTE;
            bit_q   <= '0;
            left_q  <= nbytes - CNT_W'(1);
            ones_q  <= '0;
            fin_q   <= 1'b0;
            addr_q  <= '0;
        end else if (adv) begin
            if (stuff) begin
                ones_q <= '0;
            end else begin
                ones_q <= shreg_q[0] ? ones_q + ONES_W'(1) : '0;
                bit_q  <= bit_q + 3'd1;
                if (bit_q == 3'd7) begin
                    if (left_q != '0) begin
                        shreg_q <= byte_in;
                        addr_q  <= addr_q + RA_W'(1);
                        left_q  <= left_q - CNT_W'(1);
                    end else begin
                        fin_q <= 1'b1;
                    end
                end else begin
                    shreg_q <= {1'b0, shreg_q[7:1]};
                end
            end
        end
    end
endmodule

// File: rtl/usb_ls_tx_nrzi.sv
// Line level register: 1 = J, 0 = K.
module usb_ls_tx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic ld,
    input  logic adv,
    input  logic toggle,
    output logic lvl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl <= 1'b1;
        end else if (ld) begin
            lvl <= 1'b1;
        end else if (adv && toggle) begin
            lvl <= !lvl;
        end
    end
endmodule

// File: rtl/usb_ls_tx_window.sv
// Response-window monitor: counts edges since the last received EOP.
module usb_ls_tx_window #(
    parameter int WIN_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eop,
    input  logic go,
    output logic late
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            late    <= 1'b0;
        end else begin
            late <= go && armed_q && !eop && (cnt_q >= CW'(WIN_CYC));
            if (eop) begin
                cnt_q   <= '0;
                armed_q <= 1'b1;
            end else begin
                if (go) begin
                    armed_q <= 1'b0;
                end
                if (cnt_q != CW'(WIN_CYC)) begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx #(
    parameter int CYC_PER_BIT = 8,
    parameter int MIN_BYTES   = 2,
    parameter int MAX_BYTES   = 12,
    parameter int ADDR_BITS   = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             hs_mode,
    input  logic                             hs_nak,
    input  logic [$clog2(MAX_BYTES+1)-1:0]   byte_cnt,
    output logic [$clog2(MAX_BYTES-1)-1:0]   rd_addr,
    input  logic [7:0]                       rd_data,
    input  logic                             eop_seen,
    input  logic                             rx_edge,
    input  logic [ADDR_BITS-1:0]             new_addr,
    output logic [ADDR_BITS-1:0]             dev_addr,
    output logic                             busy,
    output logic                             done,
    output logic                             too_late,
    output logic                             rx_irq,
    output logic                             dp_out,
    output logic                             dm_out,
    output logic                             drive_en
);
    import usb_ls_tx_pkg::*;

    localparam int CNT_W   = $clog2(MAX_BYTES + 1);
    localparam int RA_W    = $clog2(MAX_BYTES - 1);
    localparam int TMR_W   = $clog2(2 * CYC_PER_BIT + 1);
    localparam int WIN_CYC = (15 * CYC_PER_BIT) / 2;
    localparam int HS_LEN  = 2;

    tx_state_t        state_q, state_d;
    logic             accept, adv, tmr_last, tmr_clr, more, toggle, lvl;
    logic [TMR_W-1:0] tmr_lim;
    logic [CNT_W-1:0] ld_cnt;
    logic             hs_q;
    logic [7:0]       pid_q, byte_in;
    logic             len_ok;

    assign len_ok  = (byte_cnt >= CNT_W'(MIN_BYTES)) && (byte_cnt <= CNT_W'(MAX_BYTES));
    assign accept  = (state_q == ST_IDLE) && start && (hs_mode || len_ok);
    assign ld_cnt  = hs_mode ? CNT_W'(HS_LEN) : byte_cnt;
    assign byte_in = hs_q ? pid_q : rd_data;
    assign tmr_lim = (state_q == ST_SE0) ? TMR_W'(2 * CYC_PER_BIT) : TMR_W'(CYC_PER_BIT);
    assign tmr_clr = (state_q != ST_DATA) && (state_q != ST_SE0);

    // next state and sequencing strobes
    always_comb begin
        state_d = state_q;
        adv     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_PREP;
            ST_PREP: begin
                state_d = ST_DATA;
                adv     = 1'b1;
            end
            ST_DATA: begin
                if (tmr_last) begin
                    if (more) adv     = 1'b1;
                    else      state_d = ST_SE0;
                end
            end
            ST_SE0:  if (tmr_last) state_d = ST_EOPJ;
            ST_EOPJ: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // line outputs
    always_comb begin
        drive_en = 1'b0;
        dp_out   = 1'b0;
        dm_out   = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_PREP: dm_out = 1'b1;
            ST_DATA: begin
                drive_en = 1'b1;
                dp_out   = !lvl;
                dm_out   = lvl;
            end
            ST_SE0:  drive_en = 1'b1;
            ST_EOPJ: begin
                drive_en = 1'b1;
                dm_out   = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // packet-level registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q     <= 1'b0;
            pid_q    <= PID_ACK;
            done     <= 1'b0;
            dev_addr <= '0;
            rx_irq   <= 1'b0;
        end else begin
            if (accept) begin
                hs_q  <= hs_mode;
                pid_q <= hs_nak ? PID_NAK : PID_ACK;
            end
            done <= (state_q == ST_EOPJ);
            if ((state_q == ST_EOPJ) && !hs_q) begin
                dev_addr <= new_addr;
            end
            if (state_q == ST_EOPJ) rx_irq <= 1'b0;
            else if (rx_edge)       rx_irq <= 1'b1;
        end
    end

    usb_ls_tx_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .lim   (tmr_lim),
        .last  (tmr_last)
    );

    usb_ls_tx_ser #(.CNT_W(CNT_W), .RA_W(RA_W), .STUFF_RUN(6)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (accept),
        .nbytes  (ld_cnt),
        .adv     (adv),
        .byte_in (byte_in),
        .rd_addr (rd_addr),
        .toggle  (toggle),
        .more    (more)
    );

    usb_ls_tx_nrzi u_nrzi (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (accept),
        .adv    (adv),
        .toggle (toggle),
        .lvl    (lvl)
    );

    usb_ls_tx_window #(.WIN_CYC(WIN_CYC)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .eop   (eop_seen),
        .go    (accept),
        .late  (too_late)
    );
endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
    parameter int ADDR_BITS = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 too_late,
    input logic                 rx_irq,
    input logic                 dp_out,
    input logic                 dm_out,
    input logic                 drive_en,
    input logic [ADDR_BITS-1:0] dev_addr
);
    p_j_before_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> ($past(dm_out) && !$past(dp_out) && $past(busy)));

    p_never_both_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_out && dm_out));

    p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> (!drive_en && !dp_out && !dm_out));

    p_j_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en) |-> ($past(dm_out) && !$past(dp_out)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_addr_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> done);

    p_irq_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rx_irq);

    p_late_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        too_late |-> ($past(start) && busy));
endmodule

bind usb_ls_tx usb_ls_tx_chk #(.ADDR_BITS(ADDR_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .too_late (too_late),
    .rx_irq   (rx_irq),
    .dp_out   (dp_out),
    .dm_out   (dm_out),
    .drive_en (drive_en),
    .dev_addr (dev_addr)
);

// File: tb/usb_ls_tx_tb.sv
module usb_ls_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 8;
    localparam int HALF       = BIT_CYC / 2;
    localparam int WIN        = (15 * BIT_CYC) / 2;
    localparam int WDOG       = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, hs_mode = 1'b0, hs_nak = 1'b0;
    logic [3:0] byte_cnt = '0;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic       eop_seen = 1'b0, rx_edge = 1'b0;
    logic [6:0] new_addr = '0;
    logic [6:0] dev_addr;
    logic       busy, done, too_late, rx_irq, dp_out, dm_out, drive_en;

    logic [7:0] mem [0:15];
    logic [7:0] byt [0:15];
    logic       exp_l [0:255];
    logic       exp_s [0:255];
    int         nsl;
    int         n_chk = 0;
    int         n_err = 0;

    assign rd_data = mem[rd_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_ls_tx #(.CYC_PER_BIT(BIT_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hs_mode(hs_mode), .hs_nak(hs_nak),
        .byte_cnt(byte_cnt), .rd_addr(rd_addr), .rd_data(rd_data), .eop_seen(eop_seen),
        .rx_edge(rx_edge), .new_addr(new_addr), .dev_addr(dev_addr), .busy(busy),
        .done(done), .too_late(too_late), .rx_irq(rx_irq), .dp_out(dp_out),
        .dm_out(dm_out), .drive_en(drive_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // expected slot levels: stuffing after six ones, NRZI from J
    task automatic build(input int n);
        int   ones = 0;
        logic l = 1'b1;
        nsl = 0;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (ones == 6) begin
                    l = ~l; exp_l[nsl] = l; exp_s[nsl] = 1'b1; nsl++; ones = 0;
                end
                if (byt[i][b]) ones++;
                else begin ones = 0; l = ~l; end
                exp_l[nsl] = l; exp_s[nsl] = 1'b0; nsl++;
            end
        end
        if (ones == 6) begin
            l = ~l; exp_l[nsl] = l; exp_s[nsl] = 1'b1; nsl++;
        end
    endtask

    task automatic run_packet(input bit hs, input bit nak, input int cnt,
                              input bit exp_late, input bit poke);
        int         n = hs ? 2 : cnt;
        logic [6:0] old_addr = dev_addr;
        string      tag;
        byt[0] = 8'h80;
        for (int i = 1; i < n; i++) byt[i] = hs ? (nak ? 8'h5A : 8'hD2) : mem[i-1];
        build(n);
        start = 1'b1; hs_mode = hs; hs_nak = nak; byte_cnt = 4'(cnt);
        @(negedge clk);
        start = 1'b0; byte_cnt = 4'd0;
        check(busy && !drive_en && dm_out && !dp_out, "R2 prep J undriven",
              {busy, drive_en, dp_out, dm_out}, 4'b1001);
        check(too_late == exp_late, "R11 too_late", too_late, exp_late);
        @(negedge clk);
        check(drive_en == 1'b1, "R2 driver on", drive_en, 1);
        for (int s = 0; s < nsl; s++) begin
            repeat (HALF) @(negedge clk);
            tag = exp_s[s] ? "R5 stuffed slot" : (s == 0 ? "R4 first toggle" : (hs ? "R7 handshake slot" : "R3 data slot"));
            check(drive_en && dp_out == !exp_l[s] && dm_out == exp_l[s], tag,
                  {drive_en, dp_out, dm_out}, {1'b1, !exp_l[s], exp_l[s]});
            if (poke && s == 2) begin
                start = 1'b1; byte_cnt = 4'd5; rx_edge = 1'b1;
                @(negedge clk);
                start = 1'b0; byte_cnt = 4'd0; rx_edge = 1'b0;
                repeat (BIT_CYC - HALF - 1) @(negedge clk);
            end else begin
                repeat (BIT_CYC - HALF) @(negedge clk);
            end
        end
        check(drive_en && !dp_out && !dm_out, "R6 SE0 first", {drive_en, dp_out, dm_out}, 3'b100);
        repeat (2*BIT_CYC - 1) @(negedge clk);
        check(drive_en && !dp_out && !dm_out, "R6 SE0 last", {drive_en, dp_out, dm_out}, 3'b100);
        @(negedge clk);
        check(drive_en && !dp_out && dm_out && busy, "R6 final J",
              {busy, drive_en, dp_out, dm_out}, 4'b1101);
        check(dev_addr == old_addr, "R9 no early commit", dev_addr, old_addr);
        if (poke) check(rx_irq == 1'b1, "R10 irq during tx", rx_irq, 1);
        @(negedge clk);
        check(done && !busy, "R8 done pulse", {done, busy}, 2'b10);
        check(!drive_en && !dp_out && !dm_out, "R6 released", {drive_en, dp_out, dm_out}, 0);
        check(rx_irq == 1'b0, "R10 irq cleared", rx_irq, 0);
        if (hs) check(dev_addr == old_addr, "R9 R7 no commit on handshake", dev_addr, old_addr);
        else    check(dev_addr == new_addr, "R9 commit", dev_addr, new_addr);
        @(negedge clk);
        check(!done, "R8 done single", done, 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_err++;
        $display("FAIL R8 watchdog: actual %0d expected %0d", WDOG, 0);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !drive_en && !dp_out && !dm_out && !too_late && !rx_irq,
              "R8 reset state", {busy, done, drive_en, dp_out, dm_out, too_late, rx_irq}, 0);
        check(dev_addr == 7'd0, "R9 reset address", dev_addr, 0);

        // R1: illegal counts ignored
        foreach (byt[k]) byt[k] = 8'h00;
        for (int c = 0; c < 16; c++) begin
            if (c >= 2 && c <= 12) continue;
            start = 1'b1; hs_mode = 1'b0; byte_cnt = 4'(c);
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(negedge clk);
            check(!busy && !drive_en && !dm_out && !dp_out, "R1 illegal count ignored",
                  {busy, drive_en, dm_out}, 0);
        end

        // R10: edge flag while idle
        rx_edge = 1'b1; @(negedge clk); rx_edge = 1'b0;
        check(rx_irq == 1'b1, "R10 irq set", rx_irq, 1);

        // R3 R5: sweep lengths and patterns
        for (int p = 0; p < 4; p++) begin
            for (int c = 2; c <= 12; c++) begin
                for (int i = 0; i < 16; i++) begin
                    case (p)
                        0: mem[i] = 8'hFF;
                        1: mem[i] = 8'(i*37 + c*11 + 60);
                        2: mem[i] = 8'h00;
                        default: mem[i] = i[0] ? 8'h3F : 8'hFC;
                    endcase
                end
                new_addr = 7'(c*9 + p*3 + 1);
                run_packet(1'b0, 1'b0, c, 1'b0, (c == 7));
            end
        end

        // R7: handshakes, count input ignored, address untouched
        new_addr = 7'h55;
        run_packet(1'b1, 1'b0, 0, 1'b0, 1'b0);
        run_packet(1'b1, 1'b1, 15, 1'b0, 1'b1);

        // R11: response window edge cases
        eop_seen = 1'b1; @(negedge clk); eop_seen = 1'b0;
        repeat (WIN - 1) @(negedge clk);
        run_packet(1'b1, 1'b0, 0, 1'b0, 1'b0);
        eop_seen = 1'b1; @(negedge clk); eop_seen = 1'b0;
        repeat (WIN) @(negedge clk);
        run_packet(1'b1, 1'b1, 0, 1'b1, 1'b0);
        new_addr = 7'h2A;
        run_packet(1'b0, 1'b0, 3, 1'b0, 1'b0);

        summary();
        $finish;
    end
endmodule